// File: doc/BRIEF.md
# I2C Target Address Matcher with Four-State Strap Decoding

This block is the receiving front end of an I2C/SMBus target. It takes the raw open-drain SCL and SDA levels plus two address strap pins and runs everything on an oversampling system clock. All four inputs pass through a synchronizer and a run-length glitch filter. The block then detects START, repeated START and STOP conditions and shifts in the first byte of each transfer, most significant bit first. When the 7-bit address in that byte equals the block's own address, it acknowledges by pulling SDA low.

The own address is not a constant. Each strap pin can be tied to ground, to the supply, to SDA or to SCL. The block works out which of these it is by sampling the pin twice in every transaction. The first sample is taken at START, when SCL is high and SDA is low. The second is taken a short delay after the SCL falling edge that ends the first address bit, when SCL is low and SDA still holds the leading 1 of every valid address. These two samples tell the four connections apart. Because the classification is repeated on every START, a strap change takes effect on the next transaction.

When the address matches, the block raises a single-cycle match pulse. In the same cycle it updates the direction output with the received R/W bit. Data bytes and register pointers belong to later stages and are not handled here.

Top module: `i2c_strap_addr_match`

## Requirements
- R1: The only output towards the bus is `sda_pull_o`, where 1 means drive SDA low. Nothing drives SCL. After reset `sda_pull_o` and `match_o` are 0.
- R2: A pulse on SCL, SDA or a strap pin shorter than FILT_LEN system clocks (default 4) is ignored. It produces no START, STOP or extra bit, and a transfer containing such a pulse is still acknowledged.
- R3: START (SDA falling while SCL is high) begins address reception. STOP (SDA rising while SCL is high) returns the block to idle at any point. Bits clocked after a STOP without a new START are ignored.
- R4: The first byte is sampled on SCL rising edges, MSB first: 7 address bits, then the direction bit. On a match `rw_o` takes the direction bit (1 = read, 0 = write).
- R5: Strap connection codes are ground = 00, supply = 01, SDA = 10, SCL = 11. The own address is 3'b100, then the code of `strap_hi_i`, then the code of `strap_lo_i`, giving 7'b1000000 through 7'b1001111.
- R6: Each strap is sampled once at START and once SAMPLE_DLY clocks after the filtered SCL fall that ends the first address bit. The sample pairs decode as (0,0) ground, (1,1) supply, (0,1) SDA and (1,0) SCL.
- R7: Classification is redone on every START and repeated START. Strap settings changed between transactions are honoured by the next one.
- R8: On a match, `sda_pull_o` rises after the SCL fall that ends the eighth bit and falls after the SCL fall that ends the ninth. `match_o` pulses for exactly one clock when the pull begins.
- R9: On a mismatch, SDA is never pulled and no match pulse is given. Further bytes are ignored until the next START.
- R10: A repeated START in the middle of an address byte discards the partial byte and restarts reception, so the following full byte is matched on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| strap_hi_i | input | 1 | Level on the upper address strap pin |
| strap_lo_i | input | 1 | Level on the lower address strap pin |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| match_o | output | 1 | One-cycle pulse on an address match |
| rw_o | output | 1 | Direction bit captured at the last match |

## Verification
Every filtered edge trails its raw pin change by SYNC_STAGES + FILT_LEN clocks (6 by default). The acknowledge pull and the match pulse follow one clock later, 7 clocks after the raw SCL fall that ends the eighth bit. The release likewise comes 7 clocks after the fall that ends the ninth bit. The bench drives and samples on the falling clock edge. It reads the pull 13 clocks into a low phase, the resolved SDA level in the middle of the ninth high phase, and `rw_o` only after the STOP, so every sample lands well after its result is due and before anything else can move it.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

   typedef enum logic [1:0] {
      TIE_GND = 2'b00,
      TIE_VDD = 2'b01,
      TIE_SDA = 2'b10,
      TIE_SCL = 2'b11
   } tie_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACK,
      PH_PASS,
      PH_SKIP
   } phase_e;

   // first sample taken at START (SCL=1, SDA=0), second with SCL=0, SDA=1
   function automatic tie_e decode_tie(input logic at_start, input logic at_low);
      case ({at_start, at_low})
         2'b00:   decode_tie = TIE_GND;
         2'b11:   decode_tie = TIE_VDD;
         2'b01:   decode_tie = TIE_SDA;
         default: decode_tie = TIE_SCL;
      endcase
   endfunction

endpackage

// File: rtl/i2c_am_deglitch.sv
module i2c_am_deglitch #(
   parameter int N_LINES     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw_i,
   output logic [N_LINES-1:0] clean_o
);

   localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_am_deglitch: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("i2c_am_deglitch: FILT_LEN must be at least 1");
   end

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
      end

      if (FILT_LEN <= 1) begin : g_bypass
         assign clean_o[g] = sync_q[SYNC_STAGES-1];
      end else begin : g_count
         logic [CW-1:0] run_q;
         logic          lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
               lvl_q <= sync_q[SYNC_STAGES-1];
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign clean_o[g] = lvl_q;
      end
   end

endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_p,
   output logic stop_p,
   output logic rise_p,
   output logic fall_p
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_p = scl_q & scl_i & sda_q & ~sda_i;
   assign stop_p  = scl_q & scl_i & ~sda_q & sda_i;
   assign rise_p  = ~scl_q & scl_i;
   assign fall_p  = scl_q & ~scl_i;

endmodule

// File: rtl/i2c_am_strap_cls.sv
module i2c_am_strap_cls
   import i2c_am_pkg::*;
#(
   parameter int N_STRAPS   = 2,
   parameter int SAMPLE_DLY = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     first_i,
   input  logic                     arm_i,
   input  logic [N_STRAPS-1:0]      strap_i,
   output logic [N_STRAPS-1:0][1:0] code_o,
   output logic                     valid_o
);

   localparam int DW = $clog2(SAMPLE_DLY + 1);

   if (SAMPLE_DLY < 1) begin : g_bad_dly
      $error("i2c_am_strap_cls: SAMPLE_DLY must be at least 1");
   end

   logic [N_STRAPS-1:0]      first_q;
   logic [N_STRAPS-1:0][1:0] code_q;
   logic [DW-1:0]            dly_q;
   logic                     wait_q;
   logic                     valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         code_q  <= '0;
         dly_q   <= '0;
         wait_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (first_i) begin
         first_q <= strap_i;
         wait_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (arm_i) begin
         wait_q <= 1'b1;
         dly_q  <= '0;
      end else if (wait_q) begin
         if (dly_q == DW'(SAMPLE_DLY - 1)) begin
            wait_q  <= 1'b0;
            valid_q <= 1'b1;
            for (int k = 0; k < N_STRAPS; k++) begin
               code_q[k] <= decode_tie(first_q[k], strap_i[k]);
            end
         end else begin
            dly_q <= dly_q + 1'b1;
         end
      end
   end

   assign code_o  = code_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/i2c_strap_addr_match.sv
module i2c_strap_addr_match
   import i2c_am_pkg::*;
#(
   parameter int         ADDR_W      = 7,
   parameter logic [2:0] ADDR_PREFIX = 3'b100,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 4,
   parameter int         SAMPLE_DLY  = 2,
   parameter int         HOLD_CLKS   = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic strap_hi_i,
   input  logic strap_lo_i,
   output logic sda_pull_o,
   output logic match_o,
   output logic rw_o
);

   localparam int N_STRAPS = 2;
   localparam int SR_W     = ADDR_W + 1;
   localparam int BW       = $clog2(SR_W + 1);

   if (ADDR_W != 3 + 2 * N_STRAPS) begin : g_bad_addr
      $error("i2c_strap_addr_match: ADDR_W must equal prefix plus strap code bits");
   end
   if (SAMPLE_DLY >= HOLD_CLKS) begin : g_bad_hold
      $error("i2c_strap_addr_match: second strap sample must fall inside the SDA hold window");
   end

   // filtered lines: [0] SCL, [1] SDA, [2] low strap, [3] high strap
   logic [3:0] clean;
   logic       scl_c, sda_c;
   logic       start_p, stop_p, rise_p, fall_p;
   logic [N_STRAPS-1:0][1:0] code;
   logic       cls_valid;
   logic       arm_second;
   logic [ADDR_W-1:0] own_addr;

   phase_e          phase_q;
   logic [BW-1:0]   bit_q;
   logic [SR_W-1:0] shreg_q;
   logic            pull_q, match_q, rw_q;

   i2c_am_deglitch #(
      .N_LINES    (4),
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
   ) u_deglitch (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  ({strap_hi_i, strap_lo_i, sda_i, scl_i}),
      .clean_o(clean)
   );

   assign scl_c = clean[0];
   assign sda_c = clean[1];

   i2c_am_cond u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_c),
      .sda_i  (sda_c),
      .start_p(start_p),
      .stop_p (stop_p),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   // the fall that ends the first address bit arms the second strap sample
   assign arm_second = (phase_q == PH_ADDR) && fall_p && !start_p && !stop_p
                       && (bit_q == BW'(1));

   i2c_am_strap_cls #(
      .N_STRAPS  (N_STRAPS),
      .SAMPLE_DLY(SAMPLE_DLY)
   ) u_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .first_i(start_p),
      .arm_i  (arm_second),
      .strap_i(clean[3:2]),
      .code_o (code),
      .valid_o(cls_valid)
   );

   assign own_addr = {ADDR_PREFIX, code};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         shreg_q <= '0;
         pull_q  <= 1'b0;
         match_q <= 1'b0;
         rw_q    <= 1'b0;
      end else begin
         match_q <= 1'b0;
         if (stop_p) begin
            phase_q <= PH_IDLE;
            pull_q  <= 1'b0;
         end else if (start_p) begin
            phase_q <= PH_ADDR;
            bit_q   <= '0;
            pull_q  <= 1'b0;
         end else begin
            case (phase_q)
               PH_ADDR: begin
                  if (rise_p && (bit_q < BW'(SR_W))) begin
                     shreg_q <= {shreg_q[SR_W-2:0], sda_c};
                     bit_q   <= bit_q + 1'b1;
                  end else if (fall_p && (bit_q == BW'(SR_W))) begin
                     if (cls_valid && (shreg_q[SR_W-1:1] == own_addr)) begin
                        phase_q <= PH_ACK;
                        pull_q  <= 1'b1;
                        match_q <= 1'b1;
                        rw_q    <= shreg_q[0];
                     end else begin
                        phase_q <= PH_SKIP;
                     end
                  end
               end
               PH_ACK: begin
                  if (fall_p) begin
                     pull_q  <= 1'b0;
                     phase_q <= PH_PASS;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign match_o    = match_q;
   assign rw_o       = rw_q;

endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
   input logic clk,
   input logic rst_n,
   input logic sda_pull_o,
   input logic match_o,
   input logic scl_c,
   input logic start_p,
   input logic stop_p,
   input logic fall_p,
   input logic cls_valid
);

   // R1
   reset_release_chk: assert property (@(posedge clk) !rst_n |=> !sda_pull_o && !match_o);

   // R8
   pull_with_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> match_o);

   // R8
   match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |=> !match_o);

   // R8
   pull_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_c);

   // R8
   pull_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(fall_p || stop_p || start_p));

   // R3
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !sda_pull_o);

   // R6
   match_classified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_o |-> cls_valid);

endmodule

bind i2c_strap_addr_match i2c_am_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_pull_o(sda_pull_o),
   .match_o   (match_o),
   .scl_c     (scl_c),
   .start_p   (start_p),
   .stop_p    (stop_p),
   .fall_p    (fall_p),
   .cls_valid (cls_valid)
);

// File: tb/i2c_strap_addr_match_bench.sv
module i2c_strap_addr_match_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [1:0] tie_hi = 2'b00;
   logic [1:0] tie_lo = 2'b00;
   logic sda_bus, strap_hi, strap_lo;
   logic sda_pull_o, match_o, rw_o;
   int checks = 0;
   int fails = 0;
   int match_cnt = 0;

   always #4 clk = ~clk;

   // wired-AND open-drain SDA
   assign sda_bus = m_sda & ~sda_pull_o;

   function automatic logic tie_level(input logic [1:0] t, input logic sda, input logic scl);
      case (t)
         2'b00:   tie_level = 1'b0;
         2'b01:   tie_level = 1'b1;
         2'b10:   tie_level = sda;
         default: tie_level = scl;
      endcase
   endfunction

   assign strap_hi = tie_level(tie_hi, sda_bus, m_scl);
   assign strap_lo = tie_level(tie_lo, sda_bus, m_scl);

   i2c_strap_addr_match u_i2c_strap_addr_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .strap_hi_i(strap_hi),
      .strap_lo_i(strap_lo),
      .sda_pull_o(sda_pull_o),
      .match_o   (match_o),
      .rw_o      (rw_o)
   );

   always @(posedge clk) if (rst_n && match_o) match_cnt <= match_cnt + 1;

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // all bus tasks begin and end at an SCL falling edge except start/stop
   task automatic do_start;
      m_sda = 1'b0; wclk(24);
      m_scl = 1'b0;
   endtask

   task automatic do_rstart;
      wclk(13); m_sda = 1'b1; wclk(11);
      m_scl = 1'b1; wclk(24);
      m_sda = 1'b0; wclk(24);
      m_scl = 1'b0;
   endtask

   // kind 1: short SCL low spike, kind 2: short SDA low spike (bit must be 1)
   task automatic send_bit(input bit b, input int kind);
      wclk(13); m_sda = b; wclk(11);
      m_scl = 1'b1; wclk(8);
      if (kind == 1) begin
         m_scl = 1'b0; wclk(2); m_scl = 1'b1; wclk(14);
      end else if (kind == 2) begin
         m_sda = 1'b0; wclk(2); m_sda = 1'b1; wclk(14);
      end else begin
         wclk(16);
      end
      m_scl = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input int gl_bit, input int kind);
      for (int i = 0; i < 8; i++) send_bit(v[7-i], (i == gl_bit) ? kind : 0);
   endtask

   task automatic ack_slot(output bit acked, output bit pre);
      wclk(13); pre = sda_pull_o; m_sda = 1'b1; wclk(11);
      m_scl = 1'b1; wclk(12);
      acked = !sda_bus; wclk(12);
      m_scl = 1'b0;
   endtask

   task automatic do_stop(output bit post);
      wclk(13); post = sda_pull_o; m_sda = 1'b0; wclk(11);
      m_scl = 1'b1; wclk(24);
      m_sda = 1'b1; wclk(24);
   endtask

   task automatic xfer(input logic [1:0] th, input logic [1:0] tl, input logic [6:0] addr,
                       input bit rw, input bit exp_ack, input int gl_bit, input int kind,
                       input string req);
      bit acked, pre, post;
      int m0;
      tie_hi = th; tie_lo = tl; wclk(20);
      m0 = match_cnt;
      do_start;
      send_byte({addr, rw}, gl_bit, kind);
      ack_slot(acked, pre);
      do_stop(post);
      chk(pre == exp_ack, req, "pull before ninth clock", pre, exp_ack);
      chk(acked == exp_ack, req, "SDA low in ninth clock", acked, exp_ack);
      chk(post == 1'b0, req, "pull after ninth clock", post, 0);
      chk(match_cnt - m0 == int'(exp_ack), req, "match pulses", match_cnt - m0, exp_ack);
      if (exp_ack) chk(rw_o == rw, req, "rw_o", rw_o, rw);
   endtask

   // R4 R5 R6 R7 R8: every strap pair, both directions
   task automatic t_sweep;
      for (int h = 0; h < 4; h++)
         for (int l = 0; l < 4; l++)
            for (int d = 0; d < 2; d++)
               xfer(2'(h), 2'(l), {3'b100, 2'(h), 2'(l)}, bit'(d), 1'b1, -1, 0,
                    "R5/R6/R7/R8 sweep");
   endtask

   // R9: mismatching addresses, then a later byte without START is ignored
   task automatic t_nomatch;
      bit acked, pre, post;
      int m0;
      xfer(2'b10, 2'b11, 7'b1001010, 1'b0, 1'b0, -1, 0, "R9 low strap differs");
      xfer(2'b01, 2'b10, 7'b1001110, 1'b1, 1'b0, -1, 0, "R9 high strap differs");
      xfer(2'b00, 2'b00, 7'b0001000, 1'b0, 1'b0, -1, 0, "R9 prefix differs");
      tie_hi = 2'b11; tie_lo = 2'b01; wclk(20);
      m0 = match_cnt;
      do_start;
      send_byte({7'b1001100, 1'b0}, -1, 0);
      ack_slot(acked, pre);
      send_byte({7'b1001101, 1'b0}, -1, 0);
      ack_slot(acked, pre);
      do_stop(post);
      chk(acked == 1'b0, "R9", "second byte after mismatch acked", acked, 0);
      chk(pre == 1'b0, "R9", "pull after mismatch", pre, 0);
      chk(match_cnt == m0, "R9", "match pulses after mismatch", match_cnt - m0, 0);
   endtask

   // R2: spikes inside a transfer must not disturb it
   task automatic t_glitch;
      xfer(2'b10, 2'b01, 7'b1001001, 1'b0, 1'b1, 3, 1, "R2 SCL spike");
      xfer(2'b11, 2'b10, 7'b1001110, 1'b1, 1'b1, 0, 2, "R2 SDA spike");
      xfer(2'b01, 2'b11, 7'b1000111, 1'b0, 1'b1, 5, 1, "R2 SCL spike late bit");
   endtask

   // R10 R7: repeated START mid-byte, with straps changed before it
   task automatic t_rstart;
      bit acked, pre, post;
      int m0;
      tie_hi = 2'b00; tie_lo = 2'b01; wclk(20);
      m0 = match_cnt;
      do_start;
      for (int i = 0; i < 3; i++) send_bit(i == 0, 0);
      tie_hi = 2'b10; tie_lo = 2'b11;
      do_rstart;
      send_byte({7'b1001011, 1'b1}, -1, 0);
      ack_slot(acked, pre);
      do_stop(post);
      chk(acked == 1'b1, "R10", "ack after repeated START", acked, 1);
      chk(match_cnt - m0 == 1, "R10", "match pulses", match_cnt - m0, 1);
      chk(rw_o == 1'b1, "R7", "rw_o after repeated START", rw_o, 1);
      chk(post == 1'b0, "R10", "pull after ninth clock", post, 0);
   endtask

   // R3: STOP mid-byte, then bits without START are ignored
   task automatic t_stop_mid;
      bit acked, pre, post;
      int m0;
      tie_hi = 2'b01; tie_lo = 2'b00; wclk(20);
      m0 = match_cnt;
      do_start;
      for (int i = 0; i < 4; i++) send_bit(i == 0, 0);
      do_stop(post);
      wclk(10);
      m_scl = 1'b0;
      send_byte({7'b1000100, 1'b0}, -1, 0);
      ack_slot(acked, pre);
      do_stop(post);
      chk(pre == 1'b0, "R3", "pull without START", pre, 0);
      chk(acked == 1'b0, "R3", "ack without START", acked, 0);
      chk(match_cnt == m0, "R3", "match pulses without START", match_cnt - m0, 0);
      xfer(2'b01, 2'b00, 7'b1000100, 1'b0, 1'b1, -1, 0, "R3 recovery after STOP");
   endtask

   initial begin : main
      wclk(5);
      chk(sda_pull_o == 1'b0, "R1", "pull in reset", sda_pull_o, 0);
      chk(match_o == 1'b0, "R1", "match in reset", match_o, 0);
      rst_n = 1'b1;
      wclk(20);
      chk(sda_pull_o == 1'b0, "R1", "pull after reset", sda_pull_o, 0);
      t_sweep;
      t_nomatch;
      t_glitch;
      t_rstart;
      t_stop_mid;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule